// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous host and an external 1M x 8 asynchronous static RAM. The host presents a request with a write flag, a 20-bit address and a byte of write data; the controller turns each request into a strobe sequence on the RAM pins. Every pulse and gap is long enough to meet the RAM's nanosecond minimums. The controller drives a chip-select pair made of one active-low and one active-high line, plus an active-low write strobe, an active-low output enable, the address, and a shared bidirectional data bus.

All cycle counts come from nanosecond parameters and the clock period, rounded up to whole cycles. After reset the controller holds the RAM deselected for a power-up interval and accepts no request until that interval has passed. Between operations the RAM is deselected so that it can drop into standby. Reads are returned as a byte with a one-cycle valid pulse. After every read the controller waits for the RAM's output to float before the bus may be driven again.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, the RAM is deselected (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1, `req_ready`=0 and `rsp_valid`=0.
- R2: `req_ready` stays 0, and the RAM pins stay deselected, for exactly ceil(PWRUP_NS/CLK_NS) rising edges after reset is released, even with `req_valid` held high. It rises after the last of those edges.
- R3: In idle the RAM is deselected (`mem_cs_n`=1, `mem_cs`=0) and `req_ready`=1. While an operation runs, both selects are active (`mem_cs_n`=0, `mem_cs`=1).
- R4: An accepted write (`req_write`=1) drives `mem_we_n` low for max(ceil(WE_PULSE_NS), ceil(ADDR_TO_END_NS), ceil(DATA_SETUP_NS)) cycles, starting the cycle after acceptance. The chip stays selected, `mem_oe_n` stays 1, and the request address and data stay on `mem_a` and `mem_dq`.
- R5: After the write strobe rises, select, address and data are held for max(ceil(WR_CYCLE_NS) minus the strobe length, 1) further cycles; then the RAM is deselected.
- R6: An accepted read (`req_write`=0) holds `mem_oe_n` low with `mem_we_n`=1 and the chip selected for max(ceil(RD_CYCLE_NS), ceil(ACCESS_NS)) cycles, with `mem_a` stable.
- R7: Read data is sampled from `mem_dq` in the last access cycle. `rsp_valid` is high for exactly one cycle, the cycle after that, with the byte on `rsp_rdata`.
- R8: After `mem_oe_n` rises, the controller neither drives `mem_dq` nor selects the RAM for at least ceil(HIZ_NS) cycles.
- R9: The controller drives `mem_dq` only during write strobe and write hold cycles; it never drives it while `mem_oe_n` is low.
- R10: `mem_we_n` and `mem_oe_n` are never low in the same cycle, and `mem_we_n` is low only while the chip is selected.
- R11: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the operation and its recovery are over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_cs | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_a | output | 20 | RAM address |
| mem_dq | inout | 8 | RAM data bus |

## Verification
The embedded assertions check four rules on every cycle: the two strobes are never low together, the write strobe appears only with the chip selected, the bus is driven only with the output enable high, and the bus stays quiet for the full float gap after a read. They also check that the address holds still through a selected operation and that the response pulse lasts a single cycle. The bench's scenarios have to show the rest. That means the exact strobe and hold lengths, the power-up latency with a request already waiting, and back-to-back write/read ordering. It also means that bytes written actually land at the right addresses of a RAM model and come back, including addresses at both ends of the range and never-written locations.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;

    typedef enum logic [2:0] {
        PH_PWRUP,
        PH_IDLE,
        PH_WR_LOW,
        PH_WR_HOLD,
        PH_RD_ACC,
        PH_RD_TURN
    } phase_e;

    typedef struct packed {
        logic sel;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    // Round a nanosecond minimum up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels belonging to each phase.
    function automatic strobe_t strobes_for(input phase_e ph);
        strobe_t s;
        s = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (ph)
            PH_WR_LOW:  s = '{sel: 1'b1, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            PH_WR_HOLD: s = '{sel: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
            PH_RD_ACC:  s = '{sel: 1'b1, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            default:    s = '{sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/async_sram_timer.sv
module async_sram_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/async_sram_seq.sv
module async_sram_seq
    import async_sram_pkg::*;
#(
    parameter int W          = 16,
    parameter int CYC_WLOW   = 4,
    parameter int CYC_WHOLD  = 1,
    parameter int CYC_RD     = 5,
    parameter int CYC_TURN   = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic         t_zero,
    output logic         t_load,
    output logic [W-1:0] t_val,
    output logic         req_ready,
    output logic         accept,
    output logic         capture,
    output strobe_t      pins
);
    phase_e  state_q, state_d;
    strobe_t pins_q;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        capture = 1'b0;
        case (state_q)
            PH_PWRUP: begin
                if (t_zero) state_d = PH_IDLE;
            end
            PH_IDLE: begin
                if (req_valid) begin
                    t_load = 1'b1;
                    if (req_write) begin
                        state_d = PH_WR_LOW;
                        t_val   = W'(CYC_WLOW - 1);
                    end else begin
                        state_d = PH_RD_ACC;
                        t_val   = W'(CYC_RD - 1);
                    end
                end
            end
            PH_WR_LOW: begin
                if (t_zero) begin
                    state_d = PH_WR_HOLD;
                    t_load  = 1'b1;
                    t_val   = W'(CYC_WHOLD - 1);
                end
            end
            PH_WR_HOLD: begin
                if (t_zero) state_d = PH_IDLE;
            end
            PH_RD_ACC: begin
                if (t_zero) begin
                    capture = 1'b1;
                    state_d = PH_RD_TURN;
                    t_load  = 1'b1;
                    t_val   = W'(CYC_TURN - 1);
                end
            end
            PH_RD_TURN: begin
                if (t_zero) state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Pins are registered from the next phase so every strobe leaves a flop.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_PWRUP;
            pins_q  <= strobes_for(PH_PWRUP);
        end else begin
            state_q <= state_d;
            pins_q  <= strobes_for(state_d);
        end
    end

    assign req_ready = (state_q == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign pins      = pins_q;

    // R10: write strobe and output enable are mutually exclusive
    p_we_oe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!pins_q.we_n && !pins_q.oe_n));

    // R10: write strobe only inside a selected window
    p_we_sel_r10: assert property (@(posedge clk) disable iff (rst)
        !pins_q.we_n |-> pins_q.sel);

    // R2: chip stays deselected during the power-up wait
    p_pwrup_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_PWRUP) |-> (!pins_q.sel && !req_ready));
endmodule

// File: rtl/async_sram_data.sv
module async_sram_data #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_in;
        end
    end

    // R7: the response lasts one cycle
    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import async_sram_pkg::*;
#(
    parameter int CLK_NS         = 10,
    parameter int ADDR_W         = 20,
    parameter int DATA_W         = 8,
    parameter int WE_PULSE_NS    = 35,
    parameter int ADDR_TO_END_NS = 35,
    parameter int DATA_SETUP_NS  = 25,
    parameter int WR_CYCLE_NS    = 45,
    parameter int RD_CYCLE_NS    = 45,
    parameter int ACCESS_NS      = 45,
    parameter int HIZ_NS         = 18,
    parameter int PWRUP_NS       = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_a,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int CYC_WLOW  = imax(ns_to_cyc(WE_PULSE_NS, CLK_NS),
                               imax(ns_to_cyc(ADDR_TO_END_NS, CLK_NS),
                                    ns_to_cyc(DATA_SETUP_NS, CLK_NS)));
    localparam int CYC_WHOLD = imax(ns_to_cyc(WR_CYCLE_NS, CLK_NS) - CYC_WLOW, 1);
    localparam int CYC_RD    = imax(ns_to_cyc(RD_CYCLE_NS, CLK_NS),
                                    ns_to_cyc(ACCESS_NS, CLK_NS));
    localparam int CYC_TURN  = ns_to_cyc(HIZ_NS, CLK_NS);
    localparam int CYC_PWR   = ns_to_cyc(PWRUP_NS, CLK_NS);
    localparam int CYC_MAX   = imax(imax(CYC_PWR, CYC_WLOW),
                                    imax(CYC_RD, imax(CYC_WHOLD, CYC_TURN)));
    localparam int TW        = $clog2(CYC_MAX + 1);
    localparam int GW        = $clog2(CYC_TURN + 2);

    logic          t_load, t_zero, accept, capture;
    logic [TW-1:0] t_val;
    strobe_t       pins;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] dq_in;

    async_sram_timer #(.W(TW), .RST_VAL(CYC_PWR - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    async_sram_seq #(
        .W         (TW),
        .CYC_WLOW  (CYC_WLOW),
        .CYC_WHOLD (CYC_WHOLD),
        .CYC_RD    (CYC_RD),
        .CYC_TURN  (CYC_TURN)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .t_zero    (t_zero),
        .t_load    (t_load),
        .t_val     (t_val),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .pins      (pins)
    );

    async_sram_data #(.AW(ADDR_W), .DW(DATA_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (dq_in),
        .addr_q    (mem_a),
        .wdata_q   (wdata_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_cs_n = ~pins.sel;
    assign mem_cs   = pins.sel;
    assign mem_we_n = pins.we_n;
    assign mem_oe_n = pins.oe_n;
    assign mem_dq   = pins.drive ? wdata_q : {DATA_W{1'bz}};
    assign dq_in    = mem_dq;

    // Cycles spent with output enable high since it last went low (saturating).
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(CYC_TURN);
        end else if (!mem_oe_n) begin
            gap_q <= '0;
        end else if (gap_q < GW'(CYC_TURN)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R9: the bus is driven only with output enable high
    p_drive_oe_high_r9: assert property (@(posedge clk) disable iff (rst)
        pins.drive |-> mem_oe_n);

    // R8: drive or reselect waits out the float time after a read
    p_turn_gap_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_cs) && $past(mem_oe_n)) |-> (gap_q >= GW'(CYC_TURN)));

    // R6: address does not move while the chip stays selected
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && $past(mem_cs)) |-> $stable(mem_a));
endmodule

// File: tb/sim_async_sram_ctrl.sv
`timescale 1ns/1ps
module sim_async_sram_ctrl;
    localparam int CLK_NS = 5;
    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int N_WLOW = (cyc(35) > cyc(25)) ? cyc(35) : cyc(25);
    localparam int N_WHLD = (cyc(45) - N_WLOW > 1) ? cyc(45) - N_WLOW : 1;
    localparam int N_RD   = cyc(45);
    localparam int N_TURN = cyc(18);
    localparam int N_PWR  = cyc(200000);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, mem_cs_n, mem_cs, mem_we_n, mem_oe_n;
    logic [7:0]  rsp_rdata;
    logic [19:0] mem_a;
    wire  [7:0]  mem_dq;

    always #2.5 clk = ~clk;

    async_sram_ctrl #(.CLK_NS(CLK_NS)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
        .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_a(mem_a), .mem_dq(mem_dq)
    );

    // RAM model: stores on the rising write strobe, drives while read-enabled
    logic [7:0] ram [int];
    logic [7:0] ram_rd;
    logic       ram_drv;
    assign ram_drv = !rst && !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
    assign mem_dq  = ram_drv ? ram_rd : 8'hzz;
    always @(mem_a or mem_oe_n)
        ram_rd = ram.exists(int'(mem_a)) ? ram[int'(mem_a)] : 8'hA5;
    always @(posedge mem_we_n)
        if (!rst && !mem_cs_n && mem_cs) ram[int'(mem_a)] = mem_dq;

    // Reference model: queue of expected pin levels, one entry per cycle
    typedef struct {
        bit sel; bit we_n; bit oe_n; bit drv; bit rv;
        logic [19:0] a; logic [7:0] d;
    } exp_t;
    exp_t q[$];
    logic [7:0] exp_mem [int];
    int errors = 0, checks = 0, seen = 0, gap = 100;
    bit last_was_read = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        exp_t e;
        bit exp_ready;
        string t_rdy;
        exp_ready = 1'b0;
        if (q.size() > 0) e = q.pop_front();
        else begin
            e = '{sel:0, we_n:1, oe_n:1, drv:0, rv:0, a:'0, d:'0};
            exp_ready = (seen >= N_PWR);
        end
        t_rdy = rst ? "R1" : ((seen < N_PWR) ? "R2" : "R11");
        chk(req_ready == exp_ready, t_rdy, "req_ready", req_ready, exp_ready);
        chk({mem_cs_n, mem_cs} == (e.sel ? 2'b01 : 2'b10), rst ? "R1" : "R3",
            "select pair", {mem_cs_n, mem_cs}, e.sel ? 2'b01 : 2'b10);
        chk(mem_we_n == e.we_n, rst ? "R1" : "R4/R5", "mem_we_n", mem_we_n, e.we_n);
        chk(mem_oe_n == e.oe_n, rst ? "R1" : "R6", "mem_oe_n", mem_oe_n, e.oe_n);
        chk(rsp_valid == e.rv, rst ? "R1" : "R7", "rsp_valid", rsp_valid, e.rv);
        chk(!(!mem_we_n && !mem_oe_n), "R10", "strobe overlap", {mem_we_n, mem_oe_n}, 2'b11);
        if (e.sel) chk(mem_a == e.a, e.oe_n ? "R4" : "R6", "mem_a", mem_a, e.a);
        if (e.drv) chk(mem_dq == e.d, e.we_n ? "R5" : "R4", "write data", mem_dq, e.d);
        if (!mem_oe_n) chk(mem_dq == ram_rd, "R9", "bus contention on read", mem_dq, ram_rd);
        if (e.rv) chk(rsp_rdata == e.d, "R7", "rsp_rdata", rsp_rdata, e.d);
        // R8: gap between output enable rising and the next selection
        if (mem_cs && gap < 100 && last_was_read && gap >= 0 && !mem_oe_n == 1'b0 && mem_we_n == 1'b0)
            chk(gap >= N_TURN, "R8", "float gap before write", gap, N_TURN);
        if (!mem_oe_n) begin gap = 0; last_was_read = 1'b1; end
        else if (!mem_cs) begin if (gap < 100) gap++; end
        else if (mem_cs && last_was_read && gap > 0) begin
            chk(gap >= N_TURN, "R8", "float gap before select", gap, N_TURN);
            last_was_read = 1'b0;
        end
        if (!rst && req_valid && req_ready) begin
            if (req_write) begin
                exp_mem[int'(req_addr)] = req_wdata;
                for (int i = 0; i < N_WLOW; i++)
                    q.push_back('{sel:1, we_n:0, oe_n:1, drv:1, rv:0, a:req_addr, d:req_wdata});
                for (int i = 0; i < N_WHLD; i++)
                    q.push_back('{sel:1, we_n:1, oe_n:1, drv:1, rv:0, a:req_addr, d:req_wdata});
            end else begin
                logic [7:0] v;
                v = exp_mem.exists(int'(req_addr)) ? exp_mem[int'(req_addr)] : 8'hA5;
                for (int i = 0; i < N_RD; i++)
                    q.push_back('{sel:1, we_n:1, oe_n:0, drv:0, rv:0, a:req_addr, d:8'h00});
                for (int i = 0; i < N_TURN; i++)
                    q.push_back('{sel:0, we_n:1, oe_n:1, drv:0, rv:(i == 0), a:'0, d:v});
            end
        end
        if (!rst) seen++;
    end

    task automatic op(input bit w, input logic [19:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 190000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R2: request waits through the power-up interval
        op(1'b1, 20'h00010, 8'h3C);
        op(1'b1, 20'hFFFFF, 8'hC3);
        op(1'b1, 20'h00000, 8'h5A);
        idle(3);
        op(1'b0, 20'h00010, 8'h00);
        op(1'b0, 20'hFFFFF, 8'h00);
        op(1'b0, 20'h00000, 8'h00);
        op(1'b0, 20'h12345, 8'h00);
        // R8: read immediately followed by write and read of same address
        op(1'b0, 20'h00010, 8'h00);
        op(1'b1, 20'h00010, 8'h99);
        op(1'b0, 20'h00010, 8'h00);
        for (int k = 0; k < 16; k++) op(1'b1, 20'(k * 20'h0F0F1), 8'(k * 37 + 1));
        idle(2);
        for (int k = 15; k >= 0; k--) op(1'b0, 20'(k * 20'h0F0F1), 8'h00);
        idle(N_RD + N_TURN + 4);
        chk(q.size() == 0, "R11", "pending expectations", q.size(), 0);
        finish_run();
    end
endmodule